// File: doc/BRIEF.md
# Glitch-Free System Clock Source Switcher

This block picks the system clock from four free-running sources: a primary oscillator, a low-speed secondary oscillator, a fast internal oscillator and a slow internal RC oscillator. Software gives a two-bit source code. The block moves the system clock to the chosen source with a break-before-make handshake across clock domains, so the output never shows a runt high or low pulse. During a change the output is held low. The old source is shut off within about two of its own cycles. The new source starts after three to four of its own cycles, once it is flagged stable.

Each source has an input flag that reports it is stable. A code that asks for the secondary oscillator takes effect only while the secondary-oscillator enable input is high. Three status outputs show which source is driving the system clock: the primary, the fast internal or the secondary. When all three are low, the slow RC clock is driving it. If the output clock has stopped on a change, the new source has not yet become stable.

Top module: `clkSrcSwitch`

## Requirements
- R1: After reset the slow RC source (code 0) drives `sysClk`, and all three status outputs are low.
- R2: The codes are 0 for the slow RC, 1 for the fast internal, 2 for the secondary and 3 for the primary source. Once a change completes, `sysClk` has the period of the selected source.
- R3: Only the status output of the active source is high: `statusPrimary` for code 3, `statusFastInt` for code 1 and `statusSecondary` for code 2. None is high for code 0.
- R4: While `secEn` is low, code 2 is ignored: the source and the status outputs stay as they were.
- R5: At no time is more than one status output high, and at no time are two source gates open together.
- R6: During a change, `sysClk` never shows a high or low pulse shorter than half the period of the faster of the outgoing and incoming sources.
- R7: A change to a stable source completes with a pause of no more than two cycles of the old clock plus five cycles of the new clock. The last rising edge of the old clock and the first rising edge of the new clock are at most that far apart.
- R8: If the new source's stable flag is low, `sysClk` stays paused until the flag rises. The change then completes.
- R9: A code that arrives while a change is in progress is held. It is applied after that change completes, so the in-progress source runs first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkPrimary | input | 1 | Primary oscillator clock |
| clkSecondary | input | 1 | Low-speed secondary oscillator clock |
| clkFastInt | input | 1 | Fast internal oscillator clock |
| clkSlowRc | input | 1 | Slow internal RC clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selCode | input | 2 | Requested source code, sampled on `sysClk` |
| secEn | input | 1 | Secondary oscillator enable; code 2 is accepted only when high |
| stablePrimary | input | 1 | Primary source stable flag |
| stableSecondary | input | 1 | Secondary source stable flag |
| stableFastInt | input | 1 | Fast internal source stable flag |
| stableSlowRc | input | 1 | Slow RC source stable flag |
| sysClk | output | 1 | Gated system clock |
| statusPrimary | output | 1 | Primary source is driving `sysClk` |
| statusFastInt | output | 1 | Fast internal source is driving `sysClk` |
| statusSecondary | output | 1 | Secondary source is driving `sysClk` |

## Verification
The request is sampled on the next `sysClk` rising edge, one old cycle at most. The old gate closes two old rising edges later, on a falling edge. The new gate opens after two new rising edges plus a falling edge. The status outputs follow two `sysClk` edges after the new source starts. The bench therefore waits a fixed window after each request, longer than the slowest possible pause. It then reads the status outputs at instants that lie off every clock edge, and takes the period from two consecutive `sysClk` rising edges. Pulse widths, the longest gap between rising edges, and status exclusivity are monitored at every edge. For a change held by an unstable flag, the bench counts rising edges over a long interval and expects none.

// File: rtl/clkSrcSwitchPkg.sv
package clkSrcSwitchPkg;
  localparam int NSRC = 4;
  localparam int CODE_W = $clog2(NSRC);
  localparam int NSTAT = NSRC - 1;

  typedef enum logic [CODE_W-1:0] {
    SRC_RC   = 2'd0,
    SRC_FAST = 2'd1,
    SRC_SEC  = 2'd2,
    SRC_PRI  = 2'd3
  } srcCode_t;

  // control -> datapath: which lane is requested to drive the output
  typedef struct packed {
    logic [NSRC-1:0] selHot;
  } laneStrobe_t;
endpackage

// File: rtl/clkSrcLane.sv
module clkSrcLane #(
  parameter int SYNC_DEPTH = 2,
  parameter bit RESET_ON   = 1'b0
) (
  input  logic clkIn,
  input  logic rstN,
  input  logic wantIn,
  input  logic stableIn,
  input  logic othersOn,
  output logic enOut
);
  logic grantD;
  logic [SYNC_DEPTH-1:0] syncQ;

  // open only when requested, stable, and every other gate is shut
  assign grantD = wantIn & stableIn & ~othersOn;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) syncQ <= {SYNC_DEPTH{RESET_ON}};
    else       syncQ <= {syncQ[SYNC_DEPTH-2:0], grantD};
  end

  // gate changes only while this clock is low
  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) enOut <= RESET_ON;
    else       enOut <= syncQ[SYNC_DEPTH-1];
  end

  // R6: a gate opens only after all other gates have closed
  p_break_before_make_r6: assert property (@(negedge clkIn) disable iff (!rstN)
    $rose(enOut) |-> !othersOn);
endmodule

// File: rtl/clkSrcLanes.sv
module clkSrcLanes
  import clkSrcSwitchPkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic [NSRC-1:0] clkVec,
  input  logic            rstN,
  input  laneStrobe_t     strobe,
  input  logic [NSRC-1:0] stableVec,
  output logic            sysClk,
  output logic [NSRC-1:0] laneEn
);
  localparam logic [NSRC-1:0] ONE_HOT0 = {{(NSRC-1){1'b0}}, 1'b1};

  logic [NSRC-1:0] gatedClk;

  for (genvar gi = 0; gi < NSRC; gi++) begin : g_lane
    logic othersOn;
    assign othersOn = |(laneEn & ~(ONE_HOT0 << gi));

    clkSrcLane #(
      .SYNC_DEPTH(SYNC_DEPTH),
      .RESET_ON  (gi == int'(SRC_RC))
    ) u_lane (
      .clkIn   (clkVec[gi]),
      .rstN    (rstN),
      .wantIn  (strobe.selHot[gi]),
      .stableIn(stableVec[gi]),
      .othersOn(othersOn),
      .enOut   (laneEn[gi])
    );

    assign gatedClk[gi] = clkVec[gi] & laneEn[gi];
  end

  assign sysClk = |gatedClk;

  // R5: never two gates open together
  always_comb begin
    if (rstN) begin
      p_lanes_exclusive_r5: assert ($onehot0(laneEn));
    end
  end
endmodule

// File: rtl/clkSrcCtrl.sv
module clkSrcCtrl
  import clkSrcSwitchPkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic              sysClk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] selCode,
  input  logic              secEn,
  input  logic [NSRC-1:0]   laneEn,
  output laneStrobe_t       strobe,
  output logic [NSTAT-1:0]  statusVec
);
  localparam logic [NSRC-1:0] ONE_HOT0 = {{(NSRC-1){1'b0}}, 1'b1};
  localparam logic [NSRC-1:0] RC_HOT   = ONE_HOT0 << SRC_RC;

  logic [SYNC_DEPTH-1:0][NSRC-1:0] seenQ;
  logic [NSRC-1:0] seenNow;
  logic [NSRC-1:0] commitHot;
  srcCode_t pendCode, commitCode, nextPend;
  logic reqOk, busy;

  assign reqOk    = !((srcCode_t'(selCode) == SRC_SEC) && !secEn);
  assign nextPend = reqOk ? srcCode_t'(selCode) : pendCode;
  assign seenNow  = seenQ[SYNC_DEPTH-1];
  assign commitHot = ONE_HOT0 << commitCode;
  assign busy     = (seenNow != commitHot);

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      seenQ      <= {SYNC_DEPTH{RC_HOT}};
      pendCode   <= SRC_RC;
      commitCode <= SRC_RC;
    end else begin
      seenQ    <= {seenQ[SYNC_DEPTH-2:0], laneEn};
      pendCode <= nextPend;
      if (!busy) commitCode <= nextPend;
    end
  end

  assign strobe.selHot = commitHot;
  assign statusVec = {seenNow[SRC_SEC], seenNow[SRC_FAST], seenNow[SRC_PRI]};

  // R4: secondary only becomes pending while its enable was high
  p_sec_gated_r4: assert property (@(posedge sysClk) disable iff (!rstN)
    (pendCode == SRC_SEC && $past(pendCode) != SRC_SEC) |-> $past(secEn));

  // R5: status outputs are exclusive
  p_status_onehot_r5: assert property (@(posedge sysClk) disable iff (!rstN)
    $onehot0(statusVec));

  // R9: no new selection while a change is still in flight
  p_hold_while_busy_r9: assert property (@(posedge sysClk) disable iff (!rstN)
    busy |=> $stable(commitCode));
endmodule

// File: rtl/clkSrcSwitch.sv
module clkSrcSwitch
  import clkSrcSwitchPkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clkPrimary,
  input  logic              clkSecondary,
  input  logic              clkFastInt,
  input  logic              clkSlowRc,
  input  logic              rstN,
  input  logic [CODE_W-1:0] selCode,
  input  logic              secEn,
  input  logic              stablePrimary,
  input  logic              stableSecondary,
  input  logic              stableFastInt,
  input  logic              stableSlowRc,
  output logic              sysClk,
  output logic              statusPrimary,
  output logic              statusFastInt,
  output logic              statusSecondary
);
  logic [NSRC-1:0]  clkVec, stableVec, laneEn;
  logic [NSTAT-1:0] statusVec;
  laneStrobe_t      strobe;

  assign clkVec    = {clkPrimary, clkSecondary, clkFastInt, clkSlowRc};
  assign stableVec = {stablePrimary, stableSecondary, stableFastInt, stableSlowRc};

  clkSrcCtrl #(.SYNC_DEPTH(SYNC_DEPTH)) u_ctrl (
    .sysClk   (sysClk),
    .rstN     (rstN),
    .selCode  (selCode),
    .secEn    (secEn),
    .laneEn   (laneEn),
    .strobe   (strobe),
    .statusVec(statusVec)
  );

  clkSrcLanes #(.SYNC_DEPTH(SYNC_DEPTH)) u_lanes (
    .clkVec   (clkVec),
    .rstN     (rstN),
    .strobe   (strobe),
    .stableVec(stableVec),
    .sysClk   (sysClk),
    .laneEn   (laneEn)
  );

  assign statusPrimary   = statusVec[0];
  assign statusFastInt   = statusVec[1];
  assign statusSecondary = statusVec[2];
endmodule

// File: tb/clkSrcSwitch_test.sv
module clkSrcSwitch_test;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CLK_PERIOD = 10;  // primary
  localparam int PER_SEC    = 34;
  localparam int PER_FAST   = 6;
  localparam int PER_RC     = 50;

  logic clkPri = 0, clkSec = 0, clkFast = 0, clkRc = 0;
  always #(CLK_PERIOD/2) clkPri = ~clkPri;
  always #(PER_SEC/2)    clkSec = ~clkSec;
  always #(PER_FAST/2)   clkFast = ~clkFast;
  always #(PER_RC/2)     clkRc = ~clkRc;

  logic rstN, secEn, stPri, stSec, stFast, stRc;
  logic [1:0] selCode;
  logic sysClk, sPri, sFast, sSec;

  clkSrcSwitch uut (
    .clkPrimary(clkPri), .clkSecondary(clkSec), .clkFastInt(clkFast), .clkSlowRc(clkRc),
    .rstN(rstN), .selCode(selCode), .secEn(secEn),
    .stablePrimary(stPri), .stableSecondary(stSec), .stableFastInt(stFast), .stableSlowRc(stRc),
    .sysClk(sysClk), .statusPrimary(sPri), .statusFastInt(sFast), .statusSecondary(sSec)
  );

  int checks = 0, errors = 0, cur = 0;
  bit done = 0;

  function automatic int perOf(input int s);
    case (s)
      0: return PER_RC;
      1: return PER_FAST;
      2: return PER_SEC;
      default: return CLK_PERIOD;
    endcase
  endfunction

  function automatic logic [2:0] statusFor(input int s);  // {sec,fast,pri}
    case (s)
      1: return 3'b010;
      2: return 3'b100;
      3: return 3'b001;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int nextSrc(input int code, input bit en, input int old);
    return (code == 2 && !en) ? old : code;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // edge monitors
  realtime lastEdge, lastRise, maxGap;
  real minBound = PER_RC / 2.0;
  bit edgeArm = 0, riseArm = 0, sawPri = 0;
  int riseCount = 0, widthErr = 0, onehotErr = 0;

  always @(sysClk) if (rstN === 1'b1) begin
    if (edgeArm && ($realtime - lastEdge) < minBound) begin
      widthErr++;
      $display("FAIL R6 pulse width actual=%0t expected>=%0f", $realtime - lastEdge, minBound);
    end
    lastEdge = $realtime;
    edgeArm = 1;
  end

  always @(posedge sysClk) if (rstN === 1'b1) begin
    riseCount++;
    if (riseArm) begin
      if ($realtime - lastRise > maxGap) maxGap = $realtime - lastRise;
      if ($realtime - lastRise == CLK_PERIOD) sawPri = 1;
    end
    lastRise = $realtime;
    riseArm = 1;
  end

  always @(negedge sysClk) if (rstN === 1'b1) begin
    if ($countones({sSec, sFast, sPri}) > 1) begin
      onehotErr++;
      $display("FAIL R5 status actual=%b expected at most one set", {sSec, sFast, sPri});
    end
  end

  task automatic measurePeriod(input string req, input int expPer);
    realtime t0;
    @(posedge sysClk); t0 = $realtime;
    @(posedge sysClk);
    check(($realtime - t0) == expPer, req, "sysClk period", longint'($realtime - t0), expPer);
    #0.5;
  endtask

  task automatic switchTo(input int code, input bit en);
    int exp;
    string req;
    exp = nextSrc(code, en, cur);
    req = (code == 2 && !en) ? "R4" : "R2";
    minBound = ((perOf(cur) < perOf(exp)) ? perOf(cur) : perOf(exp)) / 2.0;
    riseArm = 0; maxGap = 0;
    selCode = code[1:0]; secEn = en;
    #2000;
    check({sSec, sFast, sPri} == statusFor(exp), (req == "R4") ? "R4" : "R3",
          "status", {sSec, sFast, sPri}, statusFor(exp));
    measurePeriod(req, perOf(exp));
    if (exp != cur)
      check(maxGap <= 2 * perOf(cur) + 5 * perOf(exp), "R7", "switch gap",
            longint'(maxGap), 2 * perOf(cur) + 5 * perOf(exp));
    cur = exp;
  endtask

  initial begin
    int rc0;
    void'($urandom(32'd4242));
    selCode = 2'd0; secEn = 0;
    stPri = 1; stSec = 1; stFast = 1; stRc = 1;
    rstN = 1;
    #3 rstN = 0;
    #40.5 rstN = 1;
    #400;
    // R1 reset state
    check({sSec, sFast, sPri} == 3'b000, "R1", "reset status", {sSec, sFast, sPri}, 0);
    measurePeriod("R1", PER_RC);

    // directed
    switchTo(1, 0);
    switchTo(2, 0);   // R4 ignored
    switchTo(2, 1);
    switchTo(3, 1);
    switchTo(0, 0);

    // R9: request arriving mid-change is held and applied afterwards
    minBound = PER_FAST / 2.0;
    sawPri = 0; riseArm = 0;
    selCode = 2'd3;
    #60 selCode = 2'd1;
    #2500;
    check({sSec, sFast, sPri} == statusFor(1), "R9", "held status", {sSec, sFast, sPri}, statusFor(1));
    check(sawPri, "R9", "intermediate primary cycles seen", sawPri, 1);
    measurePeriod("R9", PER_FAST);
    cur = 1;

    // R8: unstable target keeps the output paused
    stPri = 0;
    selCode = 2'd3;
    #700 rc0 = riseCount;
    #600;
    check(riseCount == rc0, "R8", "edges while target unstable", riseCount - rc0, 0);
    stPri = 1;
    #1500;
    check({sSec, sFast, sPri} == statusFor(3), "R8", "status after stable", {sSec, sFast, sPri}, statusFor(3));
    measurePeriod("R8", CLK_PERIOD);
    cur = 3;

    // random mix
    for (int i = 0; i < 10; i++) begin
      int code;
      bit en;
      code = int'($urandom % 4);
      en = 1'($urandom % 2);
      switchTo(code, en);
    end

    check(onehotErr == 0, "R5", "status exclusivity violations", onehotErr, 0);
    check(widthErr == 0, "R6", "runt pulses", widthErr, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule